// File: doc/BRIEF.md
# Debounced Key Matrix Scanner with Serial Host Link

The block walks a key matrix one row at a time by raising a strobe line and capturing the return lines. A new matrix state is accepted only when two scans in a row agree. When a scan differs from the one before it, the scan rhythm slows for one period so that contact bounce can settle. Each newly accepted press of an ordinary key becomes an 8-bit code, with the key number in the low seven bits and a case flag in the top bit. The case flag comes from the held shift key and a caps toggle. Presses of the shift and caps keys produce no code. The caps toggle is shown on an indicator output.

Codes wait in a small queue and go to the host one at a time over a serial frame. The frame has a data-enable line and nine bit times: eight code bits, most significant first, then an even-parity bit. After each frame the keyboard waits for the host to raise its acknowledge line. If the host reports a parity error on that edge, the keyboard sends the same code again. Otherwise it moves on. A new frame starts only after the acknowledge line has dropped again.

Top module: `kbd_scanner`

## Requirements
- R1: At most one bit of key_strobe is high at any time. A scan raises rows 0 to ROWS-1 in ascending order, each for ROW_CYC cycles.
- R2: A matrix state is accepted only when two consecutive scans capture it. A state seen in a single scan sends no code.
- R3: While successive scans match, scans start PERIOD cycles apart. After a scan that differs from the one before it, the next scan starts PERIOD*STRETCH cycles after that scan began.
- R4: Each accepted press of an ordinary key sends one code byte. Bits 6:0 hold the key number row*COLS+col, and bit 7 holds the upper-case flag.
- R5: When several presses are accepted by the same scan, their codes are sent lowest key number first.
- R6: Presses of the shift key (number SHIFT_KEY) and the caps key (number CAPS_KEY) send nothing. Key releases also send nothing.
- R7: Each accepted caps press toggles caps_led. The upper-case flag equals (shift key held) XOR caps_led.
- R8: During a frame kb_den is high for exactly 9*BIT_CYC cycles. kb_data carries the 8 code bits MSB first, then an even-parity bit, so the nine bits hold an even count of ones. Each bit lasts BIT_CYC cycles. kb_data is low whenever kb_den is low.
- R9: After a frame the block waits for host_ack to rise. If host_perr is high in that cycle, the same byte is sent again. Otherwise the next queued code follows.
- R10: A frame starts only in the cycle after host_ack was seen low.
- R11: Up to QDEPTH codes wait in the queue. Presses accepted while the link is busy are all delivered, in order, without loss.
- R12: While rst_n is low, kb_den, kb_data and caps_led are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_ret | input | COLS | Return lines; a high bit is a closed key in the strobed row |
| host_ack | input | 1 | Host completion strobe; its rise ends a transfer |
| host_perr | input | 1 | Host parity verdict, sampled when host_ack rises |
| key_strobe | output | ROWS | One-hot row strobe |
| kb_data | output | 1 | Serial frame data |
| kb_den | output | 1 | High for the duration of a frame |
| caps_led | output | 1 | Caps toggle state |

## Verification
A corrupted debounce history shows up at the ports within one or two scan periods. It causes a spurious or missing code, or a scan gap that is neither PERIOD nor PERIOD*STRETCH. Wrong case state is visible in bit 7 of the very next code. A fault in the link state shows up within a frame: a wrong enable length, a bad parity bit, a lost resend after an error report, or a frame that starts while the acknowledge line is still high.

// File: rtl/kbs_pkg.sv
package kbs_pkg;
    typedef logic [7:0] kcode_t;
    typedef enum logic [1:0] {LK_IDLE, LK_SEND, LK_WAIT, LK_REL} link_st_e;
endpackage

// File: rtl/kbs_scan.sv
module kbs_scan #(
    parameter int ROWS      = 4,
    parameter int COLS      = 8,
    parameter int ROW_CYC   = 4,
    parameter int PERIOD    = 64,
    parameter int STRETCH   = 3,
    parameter int SHIFT_KEY = 0,
    localparam int KEYS     = ROWS * COLS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] key_ret,
    input  logic            hold,
    output logic [ROWS-1:0] key_strobe,
    output logic [KEYS-1:0] new_press,
    output logic            shift_held
);
    localparam int SCAN_LEN = ROWS * ROW_CYC;
    localparam int LONG     = PERIOD * STRETCH;
    localparam int TW       = $clog2(LONG);

    typedef struct packed {
        logic [TW-1:0]   tmr;
        logic [KEYS-1:0] snap;
        logic [KEYS-1:0] prev;
        logic [KEYS-1:0] acc;
        logic [KEYS-1:0] newp;
        logic            bounce;
    } scan_t;

    scan_t q, d;

    always_comb begin
        int t;
        int lim;
        int row;
        d      = q;
        d.newp = '0;
        t      = int'(q.tmr);
        row    = t / ROW_CYC;
        lim    = q.bounce ? LONG - 1 : PERIOD - 1;
        d.tmr  = (t >= lim) ? '0 : q.tmr + 1'b1;
        if (t < SCAN_LEN && (t % ROW_CYC) == ROW_CYC - 1)
            d.snap[row*COLS +: COLS] = key_ret;
        if (t == SCAN_LEN) begin
            if (q.snap == q.prev) begin
                d.bounce = 1'b0;
                if (q.snap != q.acc && !hold) begin
                    d.acc  = q.snap;
                    d.newp = q.snap & ~q.acc;
                end
            end else begin
                d.bounce = 1'b1;
            end
            d.prev = q.snap;
        end
        key_strobe = (t < SCAN_LEN) ? (ROWS'(1) << row) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign new_press  = q.newp;
    assign shift_held = q.acc[SHIFT_KEY];
endmodule

// File: rtl/kbs_encode.sv
module kbs_encode #(
    parameter int KEYS      = 32,
    parameter int SHIFT_KEY = 0,
    parameter int CAPS_KEY  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEYS-1:0]  new_press,
    input  logic             shift_held,
    input  logic             full,
    output logic             push,
    output kbs_pkg::kcode_t  code,
    output logic             pending,
    output logic             caps_led
);
    localparam logic [KEYS-1:0] MODS = (KEYS'(1) << SHIFT_KEY) | (KEYS'(1) << CAPS_KEY);

    typedef struct packed {
        logic [KEYS-1:0] pend;
        logic            upper;
        logic            caps;
    } enc_t;

    enc_t q, d;

    always_comb begin
        int idx;
        d    = q;
        push = 1'b0;
        code = '0;
        idx  = 0;
        if (|new_press) begin
            d.caps  = q.caps ^ new_press[CAPS_KEY];
            d.upper = shift_held ^ d.caps;
            d.pend  = new_press & ~MODS;
        end else if (|q.pend && !full) begin
            for (int i = KEYS - 1; i >= 0; i--)
                if (q.pend[i]) idx = i;
            push        = 1'b1;
            code        = {q.upper, 7'(idx)};
            d.pend[idx] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pending  = |q.pend;
    assign caps_led = q.caps;
endmodule

// File: rtl/kbs_fifo.sv
module kbs_fifo #(
    parameter int DEPTH = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  kbs_pkg::kcode_t wdata,
    input  logic            pop,
    output kbs_pkg::kcode_t head,
    output logic            full,
    output logic            empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [AW-1:0]         rd;
        logic [AW-1:0]         wr;
        logic [CW-1:0]         cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) begin
            d.mem[q.wr] = wdata;
            d.wr = (int'(q.wr) == DEPTH - 1) ? '0 : q.wr + 1'b1;
        end
        if (do_pop)
            d.rd = (int'(q.rd) == DEPTH - 1) ? '0 : q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign head  = q.mem[q.rd];
endmodule

// File: rtl/kbs_link.sv
module kbs_link #(
    parameter int BIT_CYC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            empty,
    input  kbs_pkg::kcode_t head,
    input  logic            host_ack,
    input  logic            host_perr,
    output logic            pop,
    output logic            kb_den,
    output logic            kb_data
);
    import kbs_pkg::*;
    localparam int BW = $clog2(BIT_CYC + 1);

    typedef struct packed {
        link_st_e      st;
        logic [8:0]    sh;
        logic [3:0]    nbit;
        logic [BW-1:0] btmr;
        logic          retry;
    } link_t;

    link_t q, d;

    always_comb begin
        d   = q;
        pop = 1'b0;
        unique case (q.st)
            LK_IDLE: if (!empty && !host_ack) begin
                d.sh   = {head, ^head};
                d.nbit = '0;
                d.btmr = '0;
                d.st   = LK_SEND;
            end
            LK_SEND: begin
                d.btmr = q.btmr + 1'b1;
                if (int'(q.btmr) == BIT_CYC - 1) begin
                    d.btmr = '0;
                    if (q.nbit == 4'd8) begin
                        d.st = LK_WAIT;
                    end else begin
                        d.sh   = {q.sh[7:0], 1'b0};
                        d.nbit = q.nbit + 1'b1;
                    end
                end
            end
            LK_WAIT: if (host_ack) begin
                d.retry = host_perr;
                d.st    = LK_REL;
            end
            LK_REL: if (!host_ack) begin
                pop  = !q.retry;
                d.st = LK_IDLE;
            end
            default: d.st = LK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: LK_IDLE, default: '0};
        else        q <= d;
    end

    assign kb_den  = (q.st == LK_SEND);
    assign kb_data = (q.st == LK_SEND) && q.sh[8];
endmodule

// File: rtl/kbd_scanner.sv
module kbd_scanner #(
    parameter int ROWS      = 4,
    parameter int COLS      = 8,
    parameter int ROW_CYC   = 4,
    parameter int PERIOD    = 64,
    parameter int STRETCH   = 3,
    parameter int BIT_CYC   = 4,
    parameter int QDEPTH    = 4,
    parameter int SHIFT_KEY = 0,
    parameter int CAPS_KEY  = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] key_ret,
    input  logic            host_ack,
    input  logic            host_perr,
    output logic [ROWS-1:0] key_strobe,
    output logic            kb_data,
    output logic            kb_den,
    output logic            caps_led
);
    localparam int KEYS = ROWS * COLS;

    logic [KEYS-1:0] new_press;
    logic            shift_held, pending, push, full, empty, pop;
    kbs_pkg::kcode_t code, head;

    kbs_scan #(.ROWS(ROWS), .COLS(COLS), .ROW_CYC(ROW_CYC), .PERIOD(PERIOD),
               .STRETCH(STRETCH), .SHIFT_KEY(SHIFT_KEY)) u_scan (
        .clk(clk), .rst_n(rst_n), .key_ret(key_ret), .hold(pending),
        .key_strobe(key_strobe), .new_press(new_press), .shift_held(shift_held));

    kbs_encode #(.KEYS(KEYS), .SHIFT_KEY(SHIFT_KEY), .CAPS_KEY(CAPS_KEY)) u_enc (
        .clk(clk), .rst_n(rst_n), .new_press(new_press), .shift_held(shift_held),
        .full(full), .push(push), .code(code), .pending(pending), .caps_led(caps_led));

    kbs_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(code), .pop(pop),
        .head(head), .full(full), .empty(empty));

    kbs_link #(.BIT_CYC(BIT_CYC)) u_link (
        .clk(clk), .rst_n(rst_n), .empty(empty), .head(head), .host_ack(host_ack),
        .host_perr(host_perr), .pop(pop), .kb_den(kb_den), .kb_data(kb_data));
endmodule

// File: rtl/kbd_scanner_chk.sv
module kbd_scanner_chk #(
    parameter int ROWS    = 4,
    parameter int PERIOD  = 64,
    parameter int STRETCH = 3,
    parameter int BIT_CYC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ROWS-1:0] key_strobe,
    input logic            kb_den,
    input logic            kb_data,
    input logic            host_ack
);
    logic s0_q, seen_q;
    int   gap_q, dcnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0_q <= 1'b0; seen_q <= 1'b0; gap_q <= 0; dcnt_q <= 0;
        end else begin
            s0_q   <= key_strobe[0];
            dcnt_q <= kb_den ? dcnt_q + 1 : 0;
            if (key_strobe[0] && !s0_q) begin
                gap_q  <= 1;
                seen_q <= 1'b1;
            end else begin
                gap_q <= gap_q + 1;
            end
        end
    end

    // R1
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(key_strobe));

    // R3
    scan_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_strobe[0] && !s0_q && seen_q) |-> (gap_q == PERIOD || gap_q == PERIOD * STRETCH));

    // R8
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(kb_den) |-> (dcnt_q == 9 * BIT_CYC));

    // R8
    data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !kb_den |-> !kb_data);

    // R10
    start_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kb_den) |-> $past(!host_ack));
endmodule

bind kbd_scanner kbd_scanner_chk #(.ROWS(ROWS), .PERIOD(PERIOD), .STRETCH(STRETCH),
                                   .BIT_CYC(BIT_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .key_strobe(key_strobe), .kb_den(kb_den),
    .kb_data(kb_data), .host_ack(host_ack));

// File: tb/kbd_scanner_tb.sv
module kbd_scanner_tb;
    localparam int ROWS = 4, COLS = 8, ROW_CYC = 4, PERIOD = 64, STRETCH = 3;
    localparam int BIT_CYC = 4, QDEPTH = 4, KEYS = ROWS * COLS;

    logic clk = 1'b0, rst_n = 1'b0, host_ack = 1'b0, host_perr = 1'b0;
    logic [COLS-1:0] key_ret;
    logic [ROWS-1:0] key_strobe;
    logic kb_data, kb_den, caps_led;
    logic [KEYS-1:0] mat = '0;

    logic [7:0] exp_q[$];
    int checks = 0, errors = 0, frames = 0, nak_left = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        key_ret = '0;
        for (int r = 0; r < ROWS; r++)
            if (key_strobe[r]) key_ret = key_ret | mat[r*COLS +: COLS];
    end

    kbd_scanner u_dut (.clk(clk), .rst_n(rst_n), .key_ret(key_ret), .host_ack(host_ack),
        .host_perr(host_perr), .key_strobe(key_strobe), .kb_data(kb_data),
        .kb_den(kb_den), .caps_led(caps_led));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // monitor: plays the host and compares frames with the scoreboard
    initial begin
        logic [8:0] fr;
        bit nak;
        forever begin
            @(negedge clk);
            if (rst_n && kb_den) begin
                fr[8] = kb_data;
                for (int k = 1; k < 9; k++) begin
                    repeat (BIT_CYC) @(negedge clk);
                    fr[8-k] = kb_data;
                end
                repeat (BIT_CYC) @(negedge clk);
                chk(!kb_den, "R8 frame length", int'(kb_den), 0);
                chk(^fr == 1'b0, "R8 even parity", int'(fr), 0);
                frames++;
                nak = 1'b0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2/R6 unexpected code", int'(fr[8:1]), 0);
                end else begin
                    chk(fr[8:1] == exp_q[0], "R4/R5 code value", int'(fr[8:1]), int'(exp_q[0]));
                    if (nak_left > 0) begin
                        nak_left--;
                        nak = 1'b1;
                    end else begin
                        void'(exp_q.pop_front());
                    end
                end
                repeat (2) @(negedge clk);
                host_perr = nak;
                host_ack  = 1'b1;
                repeat (3) @(negedge clk);
                host_ack  = 1'b0;
                host_perr = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    task automatic settle();
        repeat (700) @(negedge clk);
        for (int i = 0; i < 5000 && (exp_q.size() != 0 || kb_den || host_ack); i++)
            @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic wait_rise();
        logic p;
        p = key_strobe[0];
        forever begin
            @(negedge clk);
            if (key_strobe[0] && !p) break;
            p = key_strobe[0];
        end
    endtask

    task automatic gap_to_rise(output int n);
        logic p;
        n = 0;
        p = key_strobe[0];
        forever begin
            @(negedge clk);
            n++;
            if (key_strobe[0] && !p) break;
            p = key_strobe[0];
        end
    endtask

    initial begin
        int f0, g;
        repeat (5) @(negedge clk);
        // R12 reset state
        chk(!kb_den, "R12 den in reset", int'(kb_den), 0);
        chk(!kb_data, "R12 data in reset", int'(kb_data), 0);
        chk(!caps_led, "R12 caps in reset", int'(caps_led), 0);
        rst_n = 1'b1;
        settle();

        // R1 row order, R3 stable period
        wait_rise();
        repeat (ROW_CYC) @(negedge clk);
        chk(key_strobe == 4'b0010, "R1 second row strobe", int'(key_strobe), 2);
        wait_rise();
        gap_to_rise(g);
        chk(g == PERIOD, "R3 stable period", g, PERIOD);

        // R4 single key
        f0 = frames;
        exp_q.push_back(8'h0A);
        mat[10] = 1'b1;
        settle();
        chk(frames - f0 == 1, "R4 one frame per press", frames - f0, 1);
        f0 = frames;
        mat[10] = 1'b0;
        settle();
        chk(frames == f0, "R6 release sends nothing", frames - f0, 0);

        // R5 two keys together
        f0 = frames;
        exp_q.push_back(8'h05);
        exp_q.push_back(8'h14);
        mat[20] = 1'b1; mat[5] = 1'b1;
        settle();
        chk(frames - f0 == 2, "R5 both keys sent", frames - f0, 2);
        mat = '0;
        settle();

        // R6 shift alone, R7 shift case
        f0 = frames;
        mat[0] = 1'b1;
        settle();
        chk(frames == f0, "R6 shift alone silent", frames - f0, 0);
        exp_q.push_back(8'h89);
        mat[9] = 1'b1;
        settle();
        chk(frames - f0 == 1, "R7 shifted key sent", frames - f0, 1);
        mat = '0;
        settle();

        // R7 caps toggle
        f0 = frames;
        mat[1] = 1'b1;
        settle();
        chk(caps_led, "R7 caps on", int'(caps_led), 1);
        chk(frames == f0, "R6 caps silent", frames - f0, 0);
        mat[1] = 1'b0;
        settle();
        exp_q.push_back(8'h8C);
        mat[12] = 1'b1;
        settle();
        mat[12] = 1'b0;
        settle();
        mat[0] = 1'b1;
        settle();
        exp_q.push_back(8'h0C);
        mat[12] = 1'b1;
        settle();
        mat = '0;
        settle();
        mat[1] = 1'b1;
        settle();
        chk(!caps_led, "R7 caps off", int'(caps_led), 0);
        mat = '0;
        settle();

        // R2 single-scan glitch, R3 stretched gap
        f0 = frames;
        wait_rise();
        mat[3] = 1'b1;
        begin
            logic p;
            g = 0;
            p = key_strobe[0];
            forever begin
                @(negedge clk);
                g++;
                if (g == ROW_CYC * ROWS + 2) mat[3] = 1'b0;
                if (key_strobe[0] && !p) break;
                p = key_strobe[0];
            end
        end
        chk(g == PERIOD * STRETCH, "R3 stretched period", g, PERIOD * STRETCH);
        settle();
        chk(frames == f0, "R2 glitch ignored", frames - f0, 0);

        // R9 parity error resend
        f0 = frames;
        nak_left = 1;
        exp_q.push_back(8'h07);
        mat[7] = 1'b1;
        settle();
        chk(frames - f0 == 2, "R9 resend after error", frames - f0, 2);
        mat = '0;
        settle();

        // R11 more presses than queue entries, R10 handshake ordering
        f0 = frames;
        foreach (exp_q[i]) ; // queue is empty here
        exp_q.push_back(8'h02); exp_q.push_back(8'h04); exp_q.push_back(8'h06);
        exp_q.push_back(8'h0D); exp_q.push_back(8'h16); exp_q.push_back(8'h1E);
        mat[2] = 1'b1; mat[4] = 1'b1; mat[6] = 1'b1;
        mat[13] = 1'b1; mat[22] = 1'b1; mat[30] = 1'b1;
        settle();
        chk(frames - f0 == 6, "R11 R10 all queued codes sent", frames - f0, 6);
        chk(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);
        mat = '0;
        settle();

        finish_run();
    end
endmodule